// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

The block holds two 8-bit counting channels behind a 16-byte register window. Each channel picks a divided internal clock from a shared prescaler, counts up, and compares its count against two compare registers, A and B. On a compare hit it can restart the count from zero and raise a one-clock interrupt pulse. When the count rolls over from its top value it raises an overflow pulse. Each pulse has its own enable bit.

Programming source code 3 into channel 0 joins the two channels into one 16-bit counter. Channel 0 holds the upper byte and channel 1 the lower byte. Channel 1's divided clock drives the joined counter. Channel 0's control register governs clearing and interrupts for the joined counter, and its events appear on the channel 0 outputs.

The bus accepts byte accesses and 16-bit accesses. A 16-bit access to a count, compare or clock register reaches both channels at once, with channel 0 in the high byte.

Top module: `cascade_timer8`

## Requirements
- R1: After reset, both compare A and compare B registers read 0xFF. The counters, the control registers and the clock registers read 0. Channel 0 status reads 0x00 and channel 1 status reads 0x10.
- R2: `addr_i[0]` selects the channel and `addr_i[3:1]` selects the register: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock. A byte read returns the value in bits 7:0 with bits 15:8 at zero. Control keeps only bits 7:3, and a byte read of selects 6 or 7 returns 0xFFFF.
- R3: In the clock register, bits 2:0 select the divider, bits 4:3 select the source and bit 7 is a plain readable flag. Source 1 counts the internal divided clock. With divider code 1 the counter advances once per cycle.
- R4: Divider codes 0 to 7 mean stopped, /1, /2, /8, /32, /64, /1024 and /8192. With code 3, any 64 consecutive cycles give exactly 8 advances. With code 0 the counter holds its value.
- R5: When an advance lands the counter on the compare A or compare B value, the matching pulse output rises for one clock, but only if its enable is set. Control bit 6 enables compare A and bit 7 enables compare B.
- R6: Control bits 4:3 select clearing: 1 clears on A and 2 clears on B. The advance that leaves the selected compare value loads 0 instead of incrementing, so the count period is the compare value plus one.
- R7: In separate mode, an advance from 0xFF to 0x00 pulses that channel's overflow output, provided control bit 5 is set.
- R8: With channel 0 source 3, the counter is {channel 0, channel 1} and is advanced by channel 1's divided clock when channel 1 source is 1. The compare value is {channel 0, channel 1} as well. Clearing and enables come from channel 0 control, events appear on channel 0 outputs, and the channel 1 outputs stay low.
- R9: In the joined mode, overflow occurs on the advance from 0xFFFF to 0x0000.
- R10: A 16-bit access at an even address to compare A, compare B, counter or clock reaches both channels, with channel 0 on bits 15:8.
- R11: A 16-bit access at an odd address, or at control or status, reads 0xFFFF, and a write made that way changes nothing.
- R12: Status bits 4:0 are stored. Channel 1 status bit 4 always reads 1.
- R13: A compare hit and an overflow on the same advance produce both pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 16-bit access, 0 = byte |
| addr_i | input | 4 | Byte address in the window |
| wdata_i | input | 16 | Write data (byte accesses use bits 7:0) |
| rdata_o | output | 16 | Read data, combinational from address |
| irq_cma_o | output | 2 | Compare A pulse per channel |
| irq_cmb_o | output | 2 | Compare B pulse per channel |
| irq_ovf_o | output | 2 | Overflow pulse per channel |

## Verification
The bench runs counts of exact length and checks the clear-on-match period for both compare registers. If the clear came one advance early or late, the final count and the pulse tally would both shift.

It sends the joined counter through a low-byte carry and through 0xFFFF. Carrying on the wrong channel or ordering the bytes backwards would show up in the byte and 16-bit readbacks. An overflow on channel 1's output, or a missing overflow on channel 0's, would also show.

Illegal 16-bit accesses are followed by byte reads of the registers they would have hit, so a write that leaks through becomes visible. A compare hit placed on the same advance as the rollover catches a design that lets one event mask the other.

// File: rtl/ct8_pkg.sv
package ct8_pkg;
  localparam int unsigned CW  = 8;
  localparam int unsigned NCH = 2;
  localparam int unsigned DW  = NCH * CW;
  localparam int unsigned AW  = 4;
  localparam int unsigned PW  = 13;

  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_STAT = 3'd1;
  localparam logic [2:0] RG_CMPA = 3'd2;
  localparam logic [2:0] RG_CMPB = 3'd3;
  localparam logic [2:0] RG_CNT  = 3'd4;
  localparam logic [2:0] RG_CLK  = 3'd5;

  localparam logic [1:0] SRC_INT  = 2'd1;
  localparam logic [1:0] SRC_CASC = 2'd3;
  localparam logic [1:0] CLR_A    = 2'd1;
  localparam logic [1:0] CLR_B    = 2'd2;

  localparam logic [CW-1:0] CTRL_MASK = 8'hF8;
  localparam logic [CW-1:0] CLK_MASK  = 8'h9F;
  localparam logic [CW-1:0] STAT_MASK = 8'h1F;
  localparam logic [CW-1:0] STAT1_FIX = 8'h10;

  // prescaler bits that must all be one for a tick
  function automatic logic [PW-1:0] div_mask(input logic [2:0] code);
    case (code)
      3'd1:    div_mask = '0;
      3'd2:    div_mask = PW'(13'h0001);
      3'd3:    div_mask = PW'(13'h0007);
      3'd4:    div_mask = PW'(13'h001F);
      3'd5:    div_mask = PW'(13'h003F);
      3'd6:    div_mask = PW'(13'h03FF);
      default: div_mask = PW'(13'h1FFF);
    endcase
  endfunction
endpackage

// File: rtl/ct8_prescale.sv
module ct8_prescale
  import ct8_pkg::*;
#(
  parameter int unsigned N = NCH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0][2:0] code_i,
  output logic [N-1:0]    tick_o
);
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PW'(1);
  end

  for (genvar g = 0; g < N; g++) begin : g_tick
    assign tick_o[g] = (code_i[g] != 3'd0) && (&(pre_q | ~div_mask(code_i[g])));
  end
endmodule

// File: rtl/ct8_step.sv
module ct8_step
  import ct8_pkg::*;
#(
  parameter int unsigned W = CW
) (
  input  logic         adv_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic [1:0]   clr_sel_i,
  output logic [W-1:0] nxt_o,
  output logic         hit_a_o,
  output logic         hit_b_o,
  output logic         wrap_o
);
  logic clr;

  always_comb begin
    clr     = (clr_sel_i == CLR_A && cnt_i == cmp_a_i) ||
              (clr_sel_i == CLR_B && cnt_i == cmp_b_i);
    nxt_o   = clr ? '0 : cnt_i + W'(1);
    hit_a_o = adv_i && (nxt_o == cmp_a_i);
    hit_b_o = adv_i && (nxt_o == cmp_b_i);
    wrap_o  = adv_i && (&cnt_i);
  end
endmodule

// File: rtl/cascade_timer8.sv
module cascade_timer8
  import ct8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          wide_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NCH-1:0] irq_cma_o,
  output logic [NCH-1:0] irq_cmb_o,
  output logic [NCH-1:0] irq_ovf_o
);
  logic [NCH-1:0][CW-1:0] ctrl_q, stat_q, cmpa_q, cmpb_q, cnt_q, clk_q;
  logic [NCH-1:0][CW-1:0] cnt_d, wbyte, rv;
  logic [NCH-1:0][2:0]    code;
  logic [NCH-1:0]         tick, wsel, adv8, ha8, hb8, wr8;
  logic [NCH-1:0]         cma_d, cmb_d, ovf_d;
  logic [NCH-1:0][CW-1:0] nxt8;
  logic [2:0]             rsel;
  logic                   wide_ok, casc, adv16, ha16, hb16, wr16;
  logic [DW-1:0]          nxt16;

  assign casc  = (clk_q[0][4:3] == SRC_CASC);
  assign adv16 = casc && tick[1] && (clk_q[1][4:3] == SRC_INT);

  // bus decode
  always_comb begin
    rsel    = addr_i[AW-1:1];
    wide_ok = !addr_i[0] && (rsel >= RG_CMPA) && (rsel <= RG_CLK);
    for (int c = 0; c < NCH; c++) begin
      wsel[c]  = req_i && we_i && (wide_i ? wide_ok : (addr_i[0] == 1'(c)));
      wbyte[c] = (wide_i && c == 0) ? wdata_i[DW-1:CW] : wdata_i[CW-1:0];
    end
  end

  ct8_prescale #(.N(NCH)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (code),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign code[g] = clk_q[g][2:0];
    assign adv8[g] = !casc && tick[g] && (clk_q[g][4:3] == SRC_INT);

    ct8_step #(.W(CW)) u_step (
      .adv_i     (adv8[g]),
      .cnt_i     (cnt_q[g]),
      .cmp_a_i   (cmpa_q[g]),
      .cmp_b_i   (cmpb_q[g]),
      .clr_sel_i (ctrl_q[g][4:3]),
      .nxt_o     (nxt8[g]),
      .hit_a_o   (ha8[g]),
      .hit_b_o   (hb8[g]),
      .wrap_o    (wr8[g])
    );

    assign cma_d[g] = (ha8[g] | ((g == 0) ? ha16 : 1'b0)) & ctrl_q[g][6];
    assign cmb_d[g] = (hb8[g] | ((g == 0) ? hb16 : 1'b0)) & ctrl_q[g][7];
    assign ovf_d[g] = (wr8[g] | ((g == 0) ? wr16 : 1'b0)) & ctrl_q[g][5];
  end

  ct8_step #(.W(DW)) u_step16 (
    .adv_i     (adv16),
    .cnt_i     ({cnt_q[0], cnt_q[1]}),
    .cmp_a_i   ({cmpa_q[0], cmpa_q[1]}),
    .cmp_b_i   ({cmpb_q[0], cmpb_q[1]}),
    .clr_sel_i (ctrl_q[0][4:3]),
    .nxt_o     (nxt16),
    .hit_a_o   (ha16),
    .hit_b_o   (hb16),
    .wrap_o    (wr16)
  );

  // counter next state, bus write wins
  always_comb begin
    cnt_d = cnt_q;
    if (adv16) begin
      cnt_d[0] = nxt16[DW-1:CW];
      cnt_d[1] = nxt16[CW-1:0];
    end
    for (int c = 0; c < NCH; c++) begin
      if (adv8[c]) cnt_d[c] = nxt8[c];
      if (wsel[c] && rsel == RG_CNT) cnt_d[c] = wbyte[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      irq_cma_o <= '0;
      irq_cmb_o <= '0;
      irq_ovf_o <= '0;
    end else begin
      cnt_q     <= cnt_d;
      irq_cma_o <= cma_d;
      irq_cmb_o <= cmb_d;
      irq_ovf_o <= ovf_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmpa_q <= '1;
      cmpb_q <= '1;
      clk_q  <= '0;
      for (int c = 0; c < NCH; c++) stat_q[c] <= (c == 1) ? STAT1_FIX : '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wsel[c]) begin
          case (rsel)
            RG_CTRL: ctrl_q[c] <= wbyte[c] & CTRL_MASK;
            RG_STAT: stat_q[c] <= (wbyte[c] & STAT_MASK) | ((c == 1) ? STAT1_FIX : '0);
            RG_CMPA: cmpa_q[c] <= wbyte[c];
            RG_CMPB: cmpb_q[c] <= wbyte[c];
            RG_CLK:  clk_q[c]  <= wbyte[c] & CLK_MASK;
            default: ;
          endcase
        end
      end
    end
  end

  // read mux
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      case (rsel)
        RG_CTRL: rv[c] = ctrl_q[c];
        RG_STAT: rv[c] = stat_q[c];
        RG_CMPA: rv[c] = cmpa_q[c];
        RG_CMPB: rv[c] = cmpb_q[c];
        RG_CNT:  rv[c] = cnt_q[c];
        RG_CLK:  rv[c] = clk_q[c];
        default: rv[c] = '1;
      endcase
    end
    if (wide_i)              rdata_o = wide_ok ? {rv[0], rv[1]} : '1;
    else if (rsel > RG_CLK)  rdata_o = '1;
    else                     rdata_o = {{CW{1'b0}}, rv[addr_i[0]]};
  end
endmodule

// File: rtl/ct8_checker.sv
module ct8_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic       wide_i,
  input logic [3:0] addr_i,
  input logic [15:0] rdata_i,
  input logic [1:0] cma_i,
  input logic [1:0] ovf_i,
  input logic       cmb1_i,
  input logic       casc_i,
  input logic [7:0] cnt0_i,
  input logic [2:0] div0_i,
  input logic       ovf_ie0_i,
  input logic       cma_ie0_i
);
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_i && div0_i == 3'd0 && !(req_i && we_i && addr_i == 4'h8)) |=> cnt0_i == $past(cnt0_i)); // R4

  AST_CMA_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cma_i[0] |-> $past(cma_ie0_i)); // R5

  AST_OVF_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i[0] |-> $past(ovf_ie0_i)); // R7

  AST_CASC_CH1_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_i |=> !(cma_i[1] || cmb1_i || ovf_i[1])); // R8

  AST_WIDE_BAD_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && wide_i && addr_i[0]) |-> rdata_i == 16'hFFFF); // R11

  AST_CH1_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && addr_i == 4'h3) |-> rdata_i[4]); // R12
endmodule

bind cascade_timer8 ct8_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .wide_i    (wide_i),
  .addr_i    (addr_i),
  .rdata_i   (rdata_o),
  .cma_i     (irq_cma_o),
  .ovf_i     (irq_ovf_o),
  .cmb1_i    (irq_cmb_o[1]),
  .casc_i    (casc),
  .cnt0_i    (cnt_q[0]),
  .div0_i    (clk_q[0][2:0]),
  .ovf_ie0_i (ctrl_q[0][5]),
  .cma_ie0_i (ctrl_q[0][6])
);

// File: tb/sim_cascade_timer8.sv
module sim_cascade_timer8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cma, cmb, ovf;

  always #10 clk = ~clk; // 50 MHz

  cascade_timer8 u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_cma_o(cma), .irq_cmb_o(cmb), .irq_ovf_o(ovf)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_t;

  sb_t  sb_q[$];
  logic rd_vld = 1'b0;
  int   total = 0, bad = 0;
  int   n_cma[2], n_cmb[2], n_ovf[2], n_both;

  // monitor: pulse tallies and scoreboard compare
  always @(negedge clk) begin
    sb_t it;
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (cma[c]) n_cma[c]++;
        if (cmb[c]) n_cmb[c]++;
        if (ovf[c]) n_ovf[c]++;
      end
      if (cma[0] && ovf[0]) n_both++;
    end
    if (rd_vld) begin
      it = sb_q.pop_front();
      total++;
      if (rdata !== it.exp) begin
        bad++;
        $display("FAIL %s read: actual=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic w, input logic [15:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; wide = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; wide = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, input logic [15:0] e, input string tag);
    sb_t it;
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; wide = w; addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_vld = 1'b1;
    @(posedge clk); #1;
    req = 1'b0; wide = 1'b0; rd_vld = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_tally();
    @(posedge clk); #1;
    for (int c = 0; c < 2; c++) begin n_cma[c] = 0; n_cmb[c] = 0; n_ovf[c] = 0; end
    n_both = 0;
  endtask

  // start at clock reg a with value v, run k idle cycles, stop with s: k+2 advances at /1
  task automatic burst(input logic [3:0] a, input logic [15:0] v, input int k, input logic [15:0] s);
    wr(a, 1'b0, v);
    repeat (k) @(posedge clk);
    wr(a, 1'b0, s);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr_tally();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'h4, 1'b0, 16'h00FF, "R1 cmpa0");
    rd(4'h7, 1'b0, 16'h00FF, "R1 cmpb1");
    rd(4'h8, 1'b1, 16'h0000, "R1 cnt");
    rd(4'h0, 1'b0, 16'h0000, "R1 ctrl0");
    rd(4'hA, 1'b1, 16'h0000, "R1 clk");
    rd(4'h2, 1'b0, 16'h0000, "R1 stat0");
    rd(4'h3, 1'b0, 16'h0010, "R1 stat1");

    // R3 /1 counting, flag bit readable
    burst(4'hA, 16'h0009, 10, 16'h0088);
    rd(4'h8, 1'b0, 16'h000C, "R3 cnt0 /1");
    rd(4'hA, 1'b0, 16'h0088, "R3 flag");

    // R4 stop code and /8
    wr(4'hB, 1'b0, 16'h0008);
    repeat (20) @(posedge clk);
    rd(4'h9, 1'b0, 16'h0000, "R4 stopped");
    burst(4'hB, 16'h000B, 62, 16'h0008);
    rd(4'h9, 1'b0, 16'h0008, "R4 div8");

    // R5 R6 clear on A with compare A pulses
    wr(4'h0, 1'b0, 16'h0048);
    wr(4'h4, 1'b0, 16'h0004);
    wr(4'h8, 1'b0, 16'h0000);
    clr_tally();
    burst(4'hA, 16'h0009, 18, 16'h0008);
    chk("R5 cma0 pulses", n_cma[0], 4);
    chk("R5 cmb0 disabled", n_cmb[0], 0);
    rd(4'h8, 1'b0, 16'h0000, "R6 clear A");

    // R7 separate overflow, R5 disabled match stays quiet
    wr(4'h1, 1'b0, 16'h0020);
    wr(4'h9, 1'b0, 16'h00FA);
    clr_tally();
    burst(4'hB, 16'h0009, 8, 16'h0008);
    chk("R7 ovf1", n_ovf[1], 1);
    chk("R5 cma1 disabled", n_cma[1], 0);
    rd(4'h9, 1'b0, 16'h0004, "R7 cnt1 wrap");

    // R6 clear on B
    wr(4'h0, 1'b0, 16'h0090);
    wr(4'h6, 1'b0, 16'h0002);
    wr(4'h8, 1'b0, 16'h0000);
    clr_tally();
    burst(4'hA, 16'h0009, 7, 16'h0008);
    chk("R6 cmb0 pulses", n_cmb[0], 3);
    rd(4'h8, 1'b0, 16'h0000, "R6 clear B");

    // R8 R10 cascade with carry across bytes
    wr(4'hA, 1'b0, 16'h0018);
    wr(4'h0, 1'b0, 16'h0060);
    wr(4'h1, 1'b0, 16'h0060);
    wr(4'h4, 1'b1, 16'h0105);
    wr(4'h6, 1'b1, 16'hFFFF);
    wr(4'h8, 1'b1, 16'h00FC);
    clr_tally();
    burst(4'hB, 16'h0009, 8, 16'h0000);
    chk("R8 cma0 16-bit", n_cma[0], 1);
    chk("R8 ch1 quiet", n_cma[1] + n_cmb[1] + n_ovf[1], 0);
    chk("R8 no ovf0", n_ovf[0], 0);
    rd(4'h8, 1'b1, 16'h0106, "R10 wide cnt");
    rd(4'h8, 1'b0, 16'h0001, "R8 upper byte");
    rd(4'h9, 1'b0, 16'h0006, "R8 lower byte");

    // R9 cascade overflow
    wr(4'h8, 1'b1, 16'hFFFE);
    clr_tally();
    burst(4'hB, 16'h0009, 0, 16'h0000);
    chk("R9 ovf0", n_ovf[0], 1);
    chk("R9 ovf1 quiet", n_ovf[1], 0);
    rd(4'h8, 1'b1, 16'h0000, "R9 wrapped");

    // R11 illegal wide accesses
    rd(4'h1, 1'b1, 16'hFFFF, "R11 odd read");
    rd(4'h0, 1'b1, 16'hFFFF, "R11 ctrl read");
    wr(4'h2, 1'b1, 16'h1F1F);
    rd(4'h2, 1'b0, 16'h0000, "R11 stat write ignored");
    wr(4'h9, 1'b1, 16'h5555);
    rd(4'h8, 1'b1, 16'h0000, "R11 odd write ignored");

    // R12 status bits
    wr(4'h3, 1'b0, 16'h0000);
    rd(4'h3, 1'b0, 16'h0010, "R12 ch1 bit4");
    wr(4'h2, 1'b0, 16'h00FF);
    rd(4'h2, 1'b0, 16'h001F, "R12 ch0 stored");

    // R2 R10 register formatting
    rd(4'hA, 1'b1, 16'h1800, "R10 wide clk");
    wr(4'h1, 1'b0, 16'h00FF);
    rd(4'h1, 1'b0, 16'h00F8, "R2 ctrl mask");
    rd(4'hC, 1'b0, 16'hFFFF, "R2 unmapped");

    // R13 match and overflow on the same advance
    wr(4'hA, 1'b0, 16'h0000);
    wr(4'h0, 1'b0, 16'h0060);
    wr(4'h4, 1'b0, 16'h0000);
    wr(4'h8, 1'b0, 16'h00FF);
    clr_tally();
    burst(4'hA, 16'h0009, 0, 16'h0000);
    chk("R13 cma0", n_cma[0], 1);
    chk("R13 ovf0", n_ovf[0], 1);
    chk("R13 same cycle", n_both, 1);
    rd(4'h8, 1'b0, 16'h0001, "R13 cnt0");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule